// File: doc/BRIEF.md
# EEPROM Phase Timing Sequencer

This block times one access to an EEPROM array. Software programs a single 32-bit wait-state register holding three cycle counts: one for a setup phase, one for an active phase and one for a hold phase. A one-cycle start request with an operation code (read, write or erase/program) starts the sequence. The sequencer then steps through setup, active and hold in that fixed order. It stays in each phase for the programmed count plus one system clock cycles and drives the strobes that the operation needs. One cycle after the hold phase ends, it raises a single-cycle done pulse.

The block has no sense of absolute time. Software picks each count so that (count + 1) clock periods cover the longest array delay that the phase must meet. The three counts are shared by every operation type, so switching between read, write and erase/program needs no register update. The counts are sampled when each phase begins. A register write during an operation therefore reaches only the phases that have not started yet.

Top module: `eeprom_phase_seq`

## Requirements
- R1: After reset the register reads 0x00000000. A write stores the hold count in bits 7:0, the active count in bits 15:8 and the setup count in bits 23:16, and `cfg_rdata` returns these fields combinationally.
- R2: Bits 31:24 of the register always read as zero, whatever value is written to them.
- R3: A `start` pulse while idle, with `op` equal to 00 (read), 01 (write) or 10 (erase/program), makes `busy` high from the next cycle. `op` = 11 is ignored, and `busy` stays low.
- R4: An accepted operation runs the setup, active and hold phases in that order, for S+1, A+1 and H+1 cycles, where S, A and H are the field values. `busy` is therefore high for exactly S+A+H+3 cycles, with the same fields for all three operation types.
- R5: `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R6: A `start` that arrives while `busy` is high is ignored. It neither changes the running sequence nor queues a second one.
- R7: Each phase loads its count at the clock edge on which it begins. A register write made during the setup phase changes the active and hold durations of the running operation, but not the setup duration.
- R8: For a write (op 01), `we_n` is low in exactly the active-phase cycles and high at all other times.
- R9: For a read (op 00), `prech` is high in exactly the setup-phase cycles. `data_valid` is high for one cycle only, the last cycle of the active phase.
- R10: For an erase/program (op 10), `pe` is high in every setup-phase and active-phase cycle and low in the hold phase. No strobe other than the one that belongs to the running operation is ever active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| start | input | 1 | Operation request, one cycle |
| op | input | 2 | Operation code: 00 read, 01 write, 10 erase/program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| prech | output | 1 | Read precharge, high during setup |
| we_n | output | 1 | Active-low write enable, low during the active phase |
| pe | output | 1 | Program enable, high during setup and active |
| data_valid | output | 1 | Read data strobe, last active-phase cycle |

## Verification
The bench sweeps every combination of setup, active and hold counts from 0 to 3, and runs each of the three operation types on every combination. Measuring the busy length and the position and length of each strobe separates an off-by-one in any single phase from an error in phase order or in the strobe decode. Setting one count to zero while the others are nonzero shows whether a minimum-length phase is dropped or merged. Three directed cases check the rest: a register write during the setup phase, start pulses during a running operation, and the reserved operation code. They show whether the fields are sampled at each phase entry, and whether unwanted requests are rejected rather than queued.

// File: rtl/eps_pkg.sv
// Package: shared encodings for the EEPROM phase sequencer.
// Assumes: op codes are fixed by the start interface; phase order is setup, active, hold.
package eps_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } eps_op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_SETUP  = 2'b01,
        PH_ACTIVE = 2'b10,
        PH_HOLD   = 2'b11
    } eps_phase_e;

    localparam int unsigned NUM_FIELDS = 3;
    localparam int unsigned FLD_HOLD   = 0;
    localparam int unsigned FLD_ACTIVE = 1;
    localparam int unsigned FLD_SETUP  = 2;

endpackage

// File: rtl/eps_wait_regs.sv
// Module: eps_wait_regs
// Stores the three minus-one-encoded phase counts and returns them on read.
// Assumes: the field with index i occupies bits [i*FIELD_W +: FIELD_W];
// bits above NUM_FIELDS*FIELD_W are reserved, read as zero and drop writes.
module eps_wait_regs
    import eps_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic [FIELD_W-1:0] setup_cnt,
    output logic [FIELD_W-1:0] active_cnt,
    output logic [FIELD_W-1:0] hold_cnt
);

    localparam int unsigned USED_W = NUM_FIELDS * FIELD_W;
    localparam int unsigned RSVD_W = DATA_W - USED_W;

    logic [FIELD_W-1:0] field_q [NUM_FIELDS];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
            // Store one count field; reset to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    field_q[gi] <= '0;
                end else if (wr_en) begin
                    field_q[gi] <= wr_data[gi*FIELD_W +: FIELD_W];
                end
            end
            // Place the field in the read word.
            assign rd_data[gi*FIELD_W +: FIELD_W] = field_q[gi];
        end

        if (RSVD_W > 0) begin : g_rsvd
            logic [RSVD_W-1:0] rsvd_unused;
            // Reserved bits are neither stored nor returned.
            assign rsvd_unused = wr_data[DATA_W-1:USED_W];
            assign rd_data[DATA_W-1:USED_W] = '0;
        end
    endgenerate

    assign setup_cnt  = field_q[FLD_SETUP];
    assign active_cnt = field_q[FLD_ACTIVE];
    assign hold_cnt   = field_q[FLD_HOLD];

endmodule

// File: rtl/eps_phase_ctrl.sv
// Module: eps_phase_ctrl
// Accepts a start request, then walks setup, active and hold phases.
// Each phase loads its count at entry and runs count+1 cycles.
// Assumes: start is ignored while a phase is running; op 11 is never accepted.
module eps_phase_ctrl
    import eps_pkg::*;
#(
    parameter int unsigned FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         op,
    input  logic [FIELD_W-1:0] setup_cnt,
    input  logic [FIELD_W-1:0] active_cnt,
    input  logic [FIELD_W-1:0] hold_cnt,
    output eps_phase_e         phase,
    output eps_op_e            op_q,
    output logic               last,
    output logic               busy,
    output logic               done
);

    eps_phase_e         phase_q;
    logic [FIELD_W-1:0] cnt_q;
    logic               done_q;
    logic               accept;
    logic               cnt_zero;

    // Take a request only when idle and with a defined op code.
    assign accept   = start && (phase_q == PH_IDLE) && (eps_op_e'(op) != OP_RSVD);
    assign cnt_zero = (cnt_q == '0);

    // Phase register, cycle counter and latched operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_READ;
        end else if (accept) begin
            phase_q <= PH_SETUP;
            cnt_q   <= setup_cnt;
            op_q    <= eps_op_e'(op);
        end else if (phase_q != PH_IDLE) begin
            if (cnt_zero) begin
                unique case (phase_q)
                    PH_SETUP: begin
                        phase_q <= PH_ACTIVE;
                        cnt_q   <= active_cnt;
                    end
                    PH_ACTIVE: begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= hold_cnt;
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end
                endcase
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // One-cycle completion pulse after the last hold cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_HOLD) && cnt_zero;
        end
    end

    assign phase = phase_q;
    assign last  = cnt_zero;
    assign busy  = (phase_q != PH_IDLE);
    assign done  = done_q;

endmodule

// File: rtl/eps_strobe_gen.sv
// Module: eps_strobe_gen
// Decodes phase and latched operation into the array strobes.
// Assumes: inputs come straight from registers, so outputs are glitch-limited decode only.
module eps_strobe_gen
    import eps_pkg::*;
(
    input  eps_phase_e phase,
    input  eps_op_e    op_q,
    input  logic       last,
    output logic       prech,
    output logic       we_n,
    output logic       pe,
    output logic       data_valid
);

    logic is_read;
    logic is_write;
    logic is_erase;

    // Operation flags, valid only while a phase runs.
    always_comb begin
        is_read  = (phase != PH_IDLE) && (op_q == OP_READ);
        is_write = (phase != PH_IDLE) && (op_q == OP_WRITE);
        is_erase = (phase != PH_IDLE) && (op_q == OP_ERASE);
    end

    // Strobe decode per operation and phase.
    always_comb begin
        prech      = is_read && (phase == PH_SETUP);
        data_valid = is_read && (phase == PH_ACTIVE) && last;
        we_n       = !(is_write && (phase == PH_ACTIVE));
        pe         = is_erase && ((phase == PH_SETUP) || (phase == PH_ACTIVE));
    end

endmodule

// File: rtl/eeprom_phase_seq.sv
// Module: eeprom_phase_seq (top)
// Wait-state register plus three-phase timing sequencer for EEPROM accesses.
// Assumes: one register at a single location; synchronous active-low reset.
module eeprom_phase_seq
    import eps_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FIELD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              start,
    input  logic [1:0]        op,
    output logic              busy,
    output logic              done,
    output logic              prech,
    output logic              we_n,
    output logic              pe,
    output logic              data_valid
);

    logic [FIELD_W-1:0] setup_cnt;
    logic [FIELD_W-1:0] active_cnt;
    logic [FIELD_W-1:0] hold_cnt;
    eps_phase_e         phase;
    eps_op_e            op_q;
    logic               last;

    eps_wait_regs #(
        .DATA_W  (DATA_W),
        .FIELD_W (FIELD_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_data    (cfg_wdata),
        .rd_data    (cfg_rdata),
        .setup_cnt  (setup_cnt),
        .active_cnt (active_cnt),
        .hold_cnt   (hold_cnt)
    );

    eps_phase_ctrl #(
        .FIELD_W (FIELD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op         (op),
        .setup_cnt  (setup_cnt),
        .active_cnt (active_cnt),
        .hold_cnt   (hold_cnt),
        .phase      (phase),
        .op_q       (op_q),
        .last       (last),
        .busy       (busy),
        .done       (done)
    );

    eps_strobe_gen u_strb (
        .phase      (phase),
        .op_q       (op_q),
        .last       (last),
        .prech      (prech),
        .we_n       (we_n),
        .pe         (pe),
        .data_valid (data_valid)
    );

endmodule

// File: rtl/eps_seq_checker.sv
// Module: eps_seq_checker
// Protocol properties of the sequencer, observed at the top-level ports.
// Assumes: bound to eeprom_phase_seq; reserved bits start at 3*FIELD_W.
module eps_seq_checker #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FIELD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              start,
    input logic [1:0]        op,
    input logic              busy,
    input logic              done,
    input logic              prech,
    input logic              we_n,
    input logic              pe,
    input logic              data_valid
);

    localparam int unsigned USED_W = 3 * FIELD_W;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1:USED_W] == '0); // R2

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op != 2'b11) |=> busy); // R3

    AST_RSVD_OP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 2'b11) |=> !busy); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R5

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !data_valid && !prech && we_n && !pe && start) |=> busy || done); // R6

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!we_n, prech, pe, data_valid})); // R10

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || prech || pe || data_valid) |-> busy); // R8

    AST_DV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid); // R9

    AST_PRECH_BEFORE_DV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prech) |-> busy && !prech); // R9

endmodule

bind eeprom_phase_seq eps_seq_checker #(
    .DATA_W  (DATA_W),
    .FIELD_W (FIELD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .start      (start),
    .op         (op),
    .busy       (busy),
    .done       (done),
    .prech      (prech),
    .we_n       (we_n),
    .pe         (pe),
    .data_valid (data_valid)
);

// File: tb/sim_eeprom_phase_seq.sv
// Bench: sweeps all phase counts 0..3 for every operation type, plus directed corner cases.
module sim_eeprom_phase_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        busy, done, prech, we_n, pe, data_valid;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    eeprom_phase_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .start(start), .op(op), .busy(busy), .done(done),
        .prech(prech), .we_n(we_n), .pe(pe), .data_valid(data_valid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] pack(input int s, input int a, input int h);
        return {8'h00, 8'(s), 8'(a), 8'(h)};
    endfunction

    // Runs one operation; midwr_k >= 0 writes midwr_val at that busy cycle index.
    task automatic run_op(input logic [1:0] o, input int s, input int a, input int h,
                          input int midwr_k, input logic [31:0] midwr_val,
                          input bit poke_start, input int exp_len);
        int k, n_prech, n_wel, n_pe, n_dv, dv_idx, wel_first, pe_first, prech_first;
        k = 0; n_prech = 0; n_wel = 0; n_pe = 0; n_dv = 0;
        dv_idx = -1; wel_first = -1; pe_first = -1; prech_first = -1;
        @(negedge clk);
        start = 1'b1;
        op = o;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R3 busy after start", busy, 1);
        while (busy === 1'b1 && k < 200) begin
            if (prech) begin n_prech++; if (prech_first < 0) prech_first = k; end
            if (!we_n) begin n_wel++; if (wel_first < 0) wel_first = k; end
            if (pe)    begin n_pe++; if (pe_first < 0) pe_first = k; end
            if (data_valid) begin n_dv++; dv_idx = k; end
            cfg_we = (k == midwr_k);
            cfg_wdata = midwr_val;
            if (poke_start) begin
                start = (k == 1) || (k == 2);
                op = 2'b01;
            end
            @(negedge clk);
            cfg_we = 1'b0;
            start = 1'b0;
            k++;
        end
        chk(k == exp_len, "R4 busy length", k, exp_len);
        chk(done === 1'b1, "R5 done after busy", done, 1);
        if (o == 2'b00) begin
            chk(n_prech == s + 1 && prech_first == 0, "R9 prech setup cycles", n_prech, s + 1);
            chk(n_dv == 1 && dv_idx == s + a + 1, "R9 data_valid position", dv_idx, s + a + 1);
            chk(n_wel == 0 && n_pe == 0, "R10 foreign strobe on read", n_wel + n_pe, 0);
        end else if (o == 2'b01) begin
            chk(n_wel == a + 1 && wel_first == s + 1, "R8 we_n low window", wel_first * 256 + n_wel, (s + 1) * 256 + a + 1);
            chk(n_prech == 0 && n_pe == 0 && n_dv == 0, "R10 foreign strobe on write", n_prech + n_pe + n_dv, 0);
        end else begin
            chk(n_pe == s + a + 2 && pe_first == 0, "R10 pe cycles", n_pe, s + a + 2);
            chk(n_prech == 0 && n_wel == 0 && n_dv == 0, "R10 foreign strobe on erase", n_prech + n_wel + n_dv, 0);
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R5 done single cycle", {done, busy}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 32'h0, "R1 reset value", cfg_rdata, 0);
        chk(busy == 1'b0 && done == 1'b0 && we_n == 1'b1 && !prech && !pe && !data_valid,
            "R3 idle outputs after reset", {busy, done, we_n, prech, pe, data_valid}, 6'b001000);

        reg_write(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h00FF_FFFF, "R2 reserved bits read zero", cfg_rdata, 32'h00FF_FFFF);
        reg_write(32'hA5C3_7E19);
        chk(cfg_rdata == 32'h00C3_7E19, "R1 field readback", cfg_rdata, 32'h00C3_7E19);

        // Reserved op code: no operation starts.
        reg_write(pack(1, 1, 1));
        @(negedge clk);
        start = 1'b1; op = 2'b11;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R3 op 11 ignored", busy, 0);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R3 op 11 no activity", {busy, done}, 0);

        // Sweep of all small counts; one register setting serves all three ops (R4).
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 4; a++)
                for (int h = 0; h < 4; h++) begin
                    reg_write(pack(s, a, h));
                    for (int o = 0; o < 3; o++)
                        run_op(2'(o), s, a, h, -1, 32'h0, 1'b0, s + a + h + 3);
                end

        // R7: write in setup changes later phases only. Setup 3 stays 4 cycles; active 5, hold 2.
        reg_write(pack(3, 0, 0));
        run_op(2'b01, 3, 5, 2, 1, pack(0, 5, 2), 1'b0, 4 + 6 + 3);
        chk(cfg_rdata == pack(0, 5, 2), "R7 mid-op write stored", cfg_rdata, pack(0, 5, 2));

        // R6: starts while busy are ignored and not queued.
        reg_write(pack(2, 2, 2));
        run_op(2'b00, 2, 2, 2, -1, 32'h0, 1'b1, 9);
        chk(busy == 1'b0, "R6 no queued start", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule